// File: doc/BRIEF.md
# Memory Decoder Port Lookup

This block finds which downstream port owns a host physical address. It holds a small bank of programmable decoders. Each decoder has a window base, a window size, a control word and a list of eight 8-bit port numbers. A shared capability field sets how many of the decoders take part in a search.

A caller programs the bank through simple 32-bit writes. It then pulses `start` with an address. The block checks one decoder per clock, in rising index order. The search stops at the first decoder whose window contains the address. If that decoder is committed, the block works out the interleave position from the address and reads the port number from that decoder's list. If the decoder is not committed, or no window matches, the search ends without a result. The end of a search is marked by a one-cycle `done` pulse, which carries `found` and `port_id`.

Top module: `hdm_route_lookup`

## Requirements
- R1: The capability field is written with `cfg_sel`=7; `cfg_dec` is ignored for this write. Its 4-bit value sits in `cfg_wdata[3:0]` and sets the number of active decoders. Code 0 gives one decoder, codes 1 to 3 give twice the code, and codes 4 and above give 8, which is the maximum. Decoders at or above the active count never take part in a search.
- R2: A window base is formed from its high word and bits 31:28 of its low word, with bits 27:0 taken as zero. The window size is formed the same way. Bits 27:0 written to a low word have no effect on matching. The select codes are 0 for base low, 1 for base high, 2 for size low and 3 for size high.
- R3: A decoder matches when base <= address < base + size. Decoders are examined from index 0 upward, and the first match ends the search.
- R4: If the first matching decoder is not committed, the search ends with `found`=0, and no later decoder is examined.
- R5: The control word (select code 4) holds the granularity code in bits 3:0, the ways code in bits 5:4 and the committed flag in bit 8. The interleave position is (address >> (8 + granularity code)) mod 2^ways code.
- R6: The port list is written with select 5 for positions 0 to 3 and select 6 for positions 4 to 7. Position p is held in byte p mod 4 of its word, that is bits 8(p mod 4)+7 down to 8(p mod 4).
- R7: When no active decoder contains the address, `found`=0 and `port_id`=0 with `done`.
- R8: A search that examines k decoders raises `done` for exactly one cycle, k clock edges after the edge that sampled `start`. `found` and `port_id` are valid in that cycle.
- R9: A `start` pulse, or a change on `lookup_addr`, while a search is running has no effect on that search and does not begin another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search using `lookup_addr` (sampled when idle) |
| lookup_addr | input | 64 | Host physical address to route |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0..6 per decoder, 7 capability) |
| cfg_dec | input | 3 | Decoder index for the write |
| cfg_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Search produced a port |
| port_id | output | 8 | Selected downstream port number |

## Verification
A search is started by a `start` strobe that is sampled on one edge. Its result shows up as `done` exactly k edges later, where k is the index of the deciding decoder plus one, or the active count on a miss. Each lookup in the bench counts clock edges from the sampling edge and reads `done` on the falling edge that follows each rising edge. It then requires the pulse to land on the predicted count, and `found` and `port_id` must be correct in that same cycle. Register writes are applied a full cycle before any search that depends on them. After a `start` given during a busy search, the bench also watches several further cycles to confirm that no second pulse appears.

// File: rtl/hdm_lookup_pkg.sv
package hdm_lookup_pkg;

  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int PORT_W = 8;

  // control word layout
  localparam int CTL_GRAN_LSB = 0;
  localparam int CTL_WAYS_LSB = 4;
  localparam int CTL_COMMIT_BIT = 8;

  // register select codes
  localparam logic [2:0] SEL_BASE_LO = 3'd0;
  localparam logic [2:0] SEL_BASE_HI = 3'd1;
  localparam logic [2:0] SEL_SIZE_LO = 3'd2;
  localparam logic [2:0] SEL_SIZE_HI = 3'd3;
  localparam logic [2:0] SEL_CTRL    = 3'd4;
  localparam logic [2:0] SEL_TGT_LO  = 3'd5;
  localparam logic [2:0] SEL_TGT_HI  = 3'd6;
  localparam logic [2:0] SEL_CAP     = 3'd7;

  typedef struct packed {
    logic [31:0] base_hi;
    logic [3:0]  base_top;
    logic [31:0] size_hi;
    logic [3:0]  size_top;
    logic        committed;
    logic [1:0]  ways;
    logic [3:0]  gran;
    logic [31:0] tgt_lo;
    logic [31:0] tgt_hi;
  } hdm_dec_t;

  // encoded count -> number of decoders (1, 2, 4, 6, 8)
  function automatic logic [4:0] count_decode(input logic [3:0] enc);
    logic [4:0] n;
    if (enc == 4'd0)      n = 5'd1;
    else if (enc >= 4'd4) n = 5'd8;
    else                  n = {enc, 1'b0};
    return n;
  endfunction

  // 64-bit window edge from high word and low-word bits 31:28
  function automatic logic [ADDR_W-1:0] window_value(input logic [31:0] hi,
                                                     input logic [3:0] top);
    return {hi, top, 28'h0};
  endfunction

  function automatic logic range_hit(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] size);
    logic [ADDR_W:0] lim;
    lim = {1'b0, base} + {1'b0, size};
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction

  // (a >> (8 + gran)) mod 2^ways
  function automatic logic [2:0] il_position(input logic [ADDR_W-1:0] a,
                                             input logic [3:0] gran,
                                             input logic [1:0] ways);
    logic [ADDR_W-1:0] sh;
    logic [3:0] span;
    logic [2:0] mask;
    sh   = a >> (6'd8 + {2'b00, gran});
    span = 4'd1 << ways;
    mask = 3'(span - 4'd1);
    return sh[2:0] & mask;
  endfunction

  function automatic logic [PORT_W-1:0] pick_port(input logic [31:0] lo_w,
                                                  input logic [31:0] hi_w,
                                                  input logic [2:0] pos);
    logic [31:0] w;
    w = pos[2] ? hi_w : lo_w;
    return w[{pos[1:0], 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/hdm_reg_bank.sv
module hdm_reg_bank
  import hdm_lookup_pkg::*;
#(
  parameter int NUM_DEC = 8,
  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [IDX_W-1:0]     cfg_dec,
  input  logic [31:0]          cfg_wdata,
  output hdm_dec_t [NUM_DEC-1:0] regs,
  output logic [3:0]           cnt_enc
);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_enc <= 4'd0;
    else if (cfg_we && cfg_sel == SEL_CAP) cnt_enc <= cfg_wdata[3:0];
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    logic wr_here;
    assign wr_here = cfg_we && (cfg_dec == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr_here) begin
        unique case (cfg_sel)
          SEL_BASE_LO: regs[g].base_top <= cfg_wdata[31:28];
          SEL_BASE_HI: regs[g].base_hi  <= cfg_wdata;
          SEL_SIZE_LO: regs[g].size_top <= cfg_wdata[31:28];
          SEL_SIZE_HI: regs[g].size_hi  <= cfg_wdata;
          SEL_CTRL: begin
            regs[g].gran      <= cfg_wdata[CTL_GRAN_LSB +: 4];
            regs[g].ways      <= cfg_wdata[CTL_WAYS_LSB +: 2];
            regs[g].committed <= cfg_wdata[CTL_COMMIT_BIT];
          end
          SEL_TGT_LO:  regs[g].tgt_lo <= cfg_wdata;
          SEL_TGT_HI:  regs[g].tgt_hi <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/hdm_dec_eval.sv
module hdm_dec_eval
  import hdm_lookup_pkg::*;
(
  input  hdm_dec_t            dec,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic                committed,
  output logic [PORT_W-1:0]   port
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] size;
  logic [2:0]        pos;

  always_comb begin
    base      = window_value(dec.base_hi, dec.base_top);
    size      = window_value(dec.size_hi, dec.size_top);
    hit       = range_hit(addr, base, size);
    committed = dec.committed;
    pos       = il_position(addr, dec.gran, dec.ways);
    port      = pick_port(dec.tgt_lo, dec.tgt_hi, pos);
  end

endmodule

// File: rtl/hdm_scan_ctrl.sv
module hdm_scan_ctrl
  import hdm_lookup_pkg::*;
#(
  parameter int NUM_DEC = 8,
  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic [4:0]         active_cnt,
  input  logic               cur_hit,
  input  logic               cur_committed,
  input  logic [PORT_W-1:0]  cur_port,
  output logic               busy,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [ADDR_W-1:0]  addr_q,
  output logic               scan_end,
  output logic               done,
  output logic               found,
  output logic [PORT_W-1:0]  port_id
);

  logic at_last;
  logic success;

  assign at_last  = (5'(cur_idx) + 5'd1) >= active_cnt;
  assign scan_end = busy && (cur_hit || at_last);
  assign success  = cur_hit && cur_committed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_idx <= '0;
      addr_q  <= '0;
      done    <= 1'b0;
      found   <= 1'b0;
      port_id <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cur_idx <= '0;
          addr_q  <= addr_in;
        end
      end else if (scan_end) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        found   <= success;
        port_id <= success ? cur_port : '0;
      end else begin
        cur_idx <= cur_idx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/hdm_route_lookup.sv
module hdm_route_lookup
  import hdm_lookup_pkg::*;
#(
  parameter int NUM_DEC = 8,
  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [63:0]        lookup_addr,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [IDX_W-1:0]   cfg_dec,
  input  logic [31:0]        cfg_wdata,
  output logic               done,
  output logic               found,
  output logic [7:0]         port_id
);

  localparam logic [4:0] NUM_DEC_L = 5'(NUM_DEC);

  hdm_dec_t [NUM_DEC-1:0] regs;
  logic [3:0]          cnt_enc;
  logic [4:0]          cnt_raw;
  logic [4:0]          active_cnt;
  logic                busy;
  logic [IDX_W-1:0]    cur_idx;
  logic [ADDR_W-1:0]   addr_q;
  logic                scan_end;
  logic                cur_hit;
  logic                cur_committed;
  logic [PORT_W-1:0]   cur_port;
  hdm_dec_t            cur_dec;

  hdm_reg_bank #(.NUM_DEC(NUM_DEC)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_dec(cfg_dec), .cfg_wdata(cfg_wdata), .regs(regs), .cnt_enc(cnt_enc)
  );

  assign cnt_raw    = count_decode(cnt_enc);
  assign active_cnt = (cnt_raw > NUM_DEC_L) ? NUM_DEC_L : cnt_raw;
  assign cur_dec    = regs[cur_idx];

  hdm_dec_eval u_eval (
    .dec(cur_dec), .addr(addr_q), .hit(cur_hit),
    .committed(cur_committed), .port(cur_port)
  );

  hdm_scan_ctrl #(.NUM_DEC(NUM_DEC)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(lookup_addr),
    .active_cnt(active_cnt), .cur_hit(cur_hit), .cur_committed(cur_committed),
    .cur_port(cur_port), .busy(busy), .cur_idx(cur_idx), .addr_q(addr_q),
    .scan_end(scan_end), .done(done), .found(found), .port_id(port_id)
  );

endmodule

// File: rtl/hdm_route_lookup_chk.sv
module hdm_route_lookup_chk #(
  parameter int NUM_DEC = 8,
  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [IDX_W-1:0] cur_idx,
  input logic [4:0]       active_cnt,
  input logic             cur_hit,
  input logic             cur_committed,
  input logic             scan_end,
  input logic             done,
  input logic             found,
  input logic [7:0]       port_id
);

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (5'(cur_idx) < active_cnt)); // R1
  AST_SCAN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (cur_idx == '0)); // R3
  AST_FIRST_MATCH_STOPS: assert property (@(posedge clk) disable iff (!rst_n) (busy && cur_hit) |=> !busy); // R3
  AST_UNCOMMITTED_FAILS: assert property (@(posedge clk) disable iff (!rst_n) (busy && cur_hit && !cur_committed) |=> (done && !found)); // R4
  AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && !found) |-> (port_id == 8'h00)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_ONE_PER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) (busy && !scan_end) |=> (busy && cur_idx == $past(cur_idx) + IDX_W'(1))); // R8
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) (busy && scan_end) |=> done); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !scan_end) |=> (busy && !done)); // R9

endmodule

bind hdm_route_lookup hdm_route_lookup_chk #(.NUM_DEC(NUM_DEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cur_idx(cur_idx),
  .active_cnt(active_cnt), .cur_hit(cur_hit), .cur_committed(cur_committed),
  .scan_end(scan_end), .done(done), .found(found), .port_id(port_id)
);

// File: tb/test_hdm_route_lookup.sv
module test_hdm_route_lookup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] lookup_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [2:0]  cfg_dec = '0;
  logic [31:0] cfg_wdata = '0;
  logic        done;
  logic        found;
  logic [7:0]  port_id;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  hdm_route_lookup i_hdm_route_lookup (
    .clk(clk), .rst_n(rst_n), .start(start), .lookup_addr(lookup_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_dec(cfg_dec), .cfg_wdata(cfg_wdata),
    .done(done), .found(found), .port_id(port_id)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [2:0] dec, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_dec = dec; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Counts rising edges after the sampling edge until done is seen.
  task automatic lookup(input logic [63:0] a, input logic exp_f,
                        input logic [7:0] exp_p, input int exp_cyc, input string req);
    int cyc = 0;
    @(negedge clk);
    start = 1'b1; lookup_addr = a;
    @(posedge clk);
    #1 start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
    end
    chk({req, " latency"}, 64'(cyc), 64'(exp_cyc));
    chk({req, " found"}, 64'(found), 64'(exp_f));
    chk({req, " port"}, 64'(port_id), 64'(exp_p));
    @(negedge clk);
    chk({req, " single pulse"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk("R8 reset done", 64'(done), 64'd0);
    chk("R7 reset found", 64'(found), 64'd0);
    chk("R7 reset port", 64'(port_id), 64'd0);
    lookup(64'h1_0000_0000, 1'b0, 8'h00, 1, "R1 R7 empty bank one decoder");
  endtask

  task automatic t_program;
    wr(3'd7, 3'd5, 32'h2);            // four decoders
    wr(3'd0, 3'd0, 32'h0FFF_FFFF);    // low bits must be dropped
    wr(3'd1, 3'd0, 32'h1);
    wr(3'd2, 3'd0, 32'h1FFF_FFFF);
    wr(3'd3, 3'd0, 32'h0);
    wr(3'd4, 3'd0, 32'h100);
    wr(3'd5, 3'd0, 32'h0000_00A5);
    wr(3'd6, 3'd0, 32'h0000_00EE);
    wr(3'd0, 3'd1, 32'h1000_0000);
    wr(3'd1, 3'd1, 32'h1);
    wr(3'd2, 3'd1, 32'h2000_0000);
    wr(3'd4, 3'd1, 32'h0);            // not committed
    wr(3'd5, 3'd1, 32'h0000_0066);
    wr(3'd0, 3'd2, 32'h1000_0000);
    wr(3'd1, 3'd2, 32'h1);
    wr(3'd2, 3'd2, 32'h1000_0000);
    wr(3'd4, 3'd2, 32'h100);
    wr(3'd5, 3'd2, 32'h0000_0077);
    wr(3'd1, 3'd3, 32'h2);
    wr(3'd3, 3'd3, 32'h1);
    wr(3'd4, 3'd3, 32'h131);          // committed, ways 3, gran 1
    wr(3'd5, 3'd3, 32'h1312_1110);
    wr(3'd6, 3'd3, 32'h1716_1514);
  endtask

  task automatic t_window;
    lookup(64'h1_0000_0000, 1'b1, 8'hA5, 1, "R2 base ignores low bits");
    lookup(64'h1_0FFF_FFFF, 1'b1, 8'hA5, 1, "R2 size top byte");
    lookup(64'h0_FFFF_FFFF, 1'b0, 8'h00, 4, "R3 below base");
    lookup(64'h1_0000_0200, 1'b1, 8'hA5, 1, "R5 ways zero position 0");
  endtask

  task automatic t_uncommitted;
    lookup(64'h1_1000_0000, 1'b0, 8'h00, 2, "R4 end exclusive then uncommitted");
    lookup(64'h1_1800_0000, 1'b0, 8'h00, 2, "R4 later match not examined");
  endtask

  task automatic t_interleave;
    lookup(64'h2_0000_0100, 1'b1, 8'h10, 4, "R5 granularity 512");
    lookup(64'h2_0000_0600, 1'b1, 8'h13, 4, "R6 position 3");
    lookup(64'h2_0000_0A00, 1'b1, 8'h15, 4, "R6 position 5");
    lookup(64'h2_0000_0E00, 1'b1, 8'h17, 4, "R6 position 7");
    lookup(64'h2_0000_1000, 1'b1, 8'h10, 4, "R5 wrap to 0");
    lookup(64'h3_0000_0000, 1'b0, 8'h00, 4, "R7 no window");
  endtask

  task automatic t_first_match;
    wr(3'd4, 3'd1, 32'h100);
    lookup(64'h1_1800_0000, 1'b1, 8'h66, 2, "R3 first match wins");
  endtask

  task automatic t_count;
    wr(3'd7, 3'd0, 32'h1);
    lookup(64'h2_0000_0000, 1'b0, 8'h00, 2, "R1 code 1 two decoders");
    wr(3'd7, 3'd3, 32'h9);
    lookup(64'h3_0000_0000, 1'b0, 8'h00, 8, "R1 code 9 capped at 8");
    wr(3'd7, 3'd2, 32'h0);
    lookup(64'h1_1800_0000, 1'b0, 8'h00, 1, "R1 code 0 one decoder");
    wr(3'd7, 3'd7, 32'h3);
    lookup(64'h2_0000_0600, 1'b1, 8'h13, 4, "R1 code 3 six decoders");
  endtask

  task automatic t_busy_start;
    int cyc = 0;
    wr(3'd7, 3'd0, 32'h2);
    @(negedge clk);
    start = 1'b1; lookup_addr = 64'h3_0000_0000;
    @(negedge clk);
    lookup_addr = 64'h1_0000_0000;   // start held high while busy
    chk("R9 no early done", 64'(done), 64'd0);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (!done) begin
      for (int i = 0; i < 20; i++) begin
        @(posedge clk);
        cyc++;
        @(negedge clk);
        if (done) break;
      end
    end
    chk("R9 latency unchanged", 64'(cyc), 64'd4);
    chk("R9 result of first address", 64'(found), 64'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 no second search", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_window();
    t_uncommitted();
    t_interleave();
    t_first_match();
    t_count();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule